// File: doc/BRIEF.md
# Modulo Address Counter with Lap Bit

This block is the pointer unit of a two-clock FIFO, one instance per clock domain. It keeps a buffer address that counts from zero up to `DEPTH-1` and then returns to zero. `DEPTH` may be any positive integer, including values that are not a power of two. Alongside the address it keeps a single lap bit that inverts on every wrap. The lap bit is what tells a full buffer apart from an empty one when the two addresses are equal.

The unit exports a registered pointer word, with the lap bit above the address, for a synchronizer to carry into the other domain. A comparator checks the local word against the word that arrived from the other side. A write-side unit (`WRITE_SIDE=1`) reports full: the addresses are equal and the lap bits differ. A read-side unit (`WRITE_SIDE=0`) reports empty: the addresses are equal and the lap bits match. If the remote word lags, the flag it produces can only err on the safe side.

The comparator classifies the pointer pair into one of three named states:
- DRAINED: the addresses are equal and the lap bits are equal.
- PACKED: the addresses are equal and the lap bits differ.
- HOLDS_ITEMS: any other pair.

These states are recomputed every cycle from the two words and have no transitions of their own.

The counter has two running behaviours:
- step: an advance that adds one to the address.
- wrap: an advance taken at `DEPTH-1`, which reloads the address to zero and inverts the lap bit.

Clear overrides both behaviours.

Top module: `lap_ptr_unit`

## Requirements
- R1: After a synchronous clear the address is 0 and the lap bit is 0. An advance asserted during the clear cycle is ignored.
- R2: An advance while the address is below `DEPTH-1` raises the address by exactly one on the next clock edge and leaves the lap bit unchanged.
- R3: An advance while the address equals `DEPTH-1` reloads the address to 0 and inverts the lap bit. The reload wins over the increment.
- R4: Without an advance, the address and the lap bit hold their values.
- R5: The address never exceeds `DEPTH-1`. The address width is ceil(log2(DEPTH)), with a minimum of 1 bit.
- R6: `ptr_word` equals {lap, addr}: the lap bit at bit position ADDR_W and the address in bits ADDR_W-1:0. It changes only on the clock edge that follows an advance or a clear.
- R7: With `WRITE_SIDE=1`, `full` is 1 exactly when the local and remote addresses are equal and their lap bits differ, and `empty` is held at 0.
- R8: With `WRITE_SIDE=0`, `empty` is 1 exactly when the local and remote addresses are equal and their lap bits are equal, and `full` is held at 0.
- R9: The unit supports non-power-of-two depths, and `DEPTH=1`. With `DEPTH=1` the address stays 0 and every advance inverts the lap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of this domain |
| clr | input | 1 | Synchronous clear, active high |
| advance | input | 1 | Step the pointer by one place |
| remote_word | input | ADDR_W+1 | Pointer word from the other domain, lap bit on top |
| addr | output | ADDR_W | Current buffer address |
| lap | output | 1 | Lap bit, inverted on every wrap |
| ptr_word | output | ADDR_W+1 | Registered {lap, addr} for export |
| empty | output | 1 | Read side: no items between the pointers |
| full | output | 1 | Write side: the buffer holds DEPTH items |

## Verification
Some behaviours are checked by assertions on every cycle:
- the single-step increment;
- the reload-and-invert at `DEPTH-1`;
- holding when there is no advance;
- the address staying within range.

Other behaviours only the bench scenarios can show:
- the clear dominating an advance;
- full and empty tracking the true occupancy while a writer and a reader unit race each other through several laps of a depth-5 buffer;
- the `DEPTH=1` corner, where every advance is a wrap.

// File: rtl/lap_ptr_pkg.sv
package lap_ptr_pkg;

    typedef enum logic [1:0] {
        ST_HOLDS_ITEMS = 2'd0,
        ST_DRAINED     = 2'd1,
        ST_PACKED      = 2'd2
    } ptr_rel_t;

    function automatic int addr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/lap_ptr_counter.sv
module lap_ptr_counter
    import lap_ptr_pkg::*;
#(
    parameter int DEPTH  = 5,
    parameter int ADDR_W = addr_width(DEPTH)
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              lap
);

    localparam logic [ADDR_W-1:0] LAST    = ADDR_W'(DEPTH - 1);
    localparam bit                POW2_OK = (DEPTH > 1) && (DEPTH == (1 << ADDR_W));

    logic at_last;
    logic [ADDR_W-1:0] addr_inc;

    generate
        if (POW2_OK) begin : g_pow2
            // Natural rollover of the adder is the reload to zero.
            assign at_last  = &addr;
            assign addr_inc = addr + 1'b1;
        end else begin : g_modulo
            assign at_last  = (addr == LAST);
            assign addr_inc = at_last ? '0 : addr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) begin
            addr <= '0;
            lap  <= 1'b0;
        end else if (advance) begin
            addr <= addr_inc;
            if (at_last) begin
                lap <= ~lap;
            end
        end
    end

    // R2: a step below the last slot adds exactly one
    a_r2_single_step: assert property (@(posedge clk) disable iff (clr)
        (advance && addr != LAST) |=> (addr == $past(addr) + 1'b1) && (lap == $past(lap)));

    // R3: a step at the last slot reloads zero and inverts the lap bit
    a_r3_wrap_reload: assert property (@(posedge clk) disable iff (clr)
        (advance && addr == LAST) |=> (addr == '0) && (lap != $past(lap)));

    // R4: no advance, no change
    a_r4_hold: assert property (@(posedge clk) disable iff (clr)
        !advance |=> $stable(addr) && $stable(lap));

    // R5: address stays inside the buffer
    a_r5_in_range: assert property (@(posedge clk) disable iff (clr)
        addr <= LAST);

endmodule

// File: rtl/lap_ptr_compare.sv
module lap_ptr_compare
    import lap_ptr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W:0] local_word,
    input  logic [ADDR_W:0] remote_word,
    output ptr_rel_t        relation
);

    logic addr_eq;
    logic lap_eq;

    assign addr_eq = (local_word[ADDR_W-1:0] == remote_word[ADDR_W-1:0]);
    assign lap_eq  = (local_word[ADDR_W] == remote_word[ADDR_W]);

    always_comb begin
        unique case ({addr_eq, lap_eq})
            2'b11:   relation = ST_DRAINED;
            2'b10:   relation = ST_PACKED;
            default: relation = ST_HOLDS_ITEMS;
        endcase
    end

endmodule

// File: rtl/lap_ptr_unit.sv
module lap_ptr_unit
    import lap_ptr_pkg::*;
#(
    parameter int DEPTH      = 5,
    parameter bit WRITE_SIDE = 1'b1,
    parameter int ADDR_W     = addr_width(DEPTH)
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              advance,
    input  logic [ADDR_W:0]   remote_word,
    output logic [ADDR_W-1:0] addr,
    output logic              lap,
    output logic [ADDR_W:0]   ptr_word,
    output logic              empty,
    output logic              full
);

    ptr_rel_t relation;

    lap_ptr_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_counter (
        .clk     (clk),
        .clr     (clr),
        .advance (advance),
        .addr    (addr),
        .lap     (lap)
    );

    // Both fields come straight from flops, so the exported word is registered.
    assign ptr_word = {lap, addr};

    lap_ptr_compare #(.ADDR_W(ADDR_W)) u_compare (
        .local_word  (ptr_word),
        .remote_word (remote_word),
        .relation    (relation)
    );

    generate
        if (WRITE_SIDE) begin : g_write
            assign full  = (relation == ST_PACKED);
            assign empty = 1'b0;
        end else begin : g_read
            assign empty = (relation == ST_DRAINED);
            assign full  = 1'b0;
        end
    endgenerate

    // R6: exported word moves only after an advance
    a_r6_word_stable: assert property (@(posedge clk) disable iff (clr)
        !advance |=> $stable(ptr_word));

endmodule

// File: tb/lap_ptr_unit_test.sv
module lap_ptr_unit_test;

    localparam int DEPTH = 5;
    localparam int AW    = 3;

    logic clk = 1'b0;
    logic clr = 1'b1;
    logic wr_adv = 1'b0;
    logic rd_adv = 1'b0;
    logic one_adv = 1'b0;

    logic [AW-1:0] wr_addr, rd_addr;
    logic          wr_lap, rd_lap;
    logic [AW:0]   wr_word, rd_word;
    logic          wr_empty, wr_full, rd_empty, rd_full;

    logic [0:0] one_addr;
    logic       one_lap, one_empty, one_full;
    logic [1:0] one_word;

    int checks = 0;
    int fails  = 0;
    int wtot = 0;
    int rtot = 0;
    int otot = 0;

    always #5 clk = ~clk;

    lap_ptr_unit #(.DEPTH(DEPTH), .WRITE_SIDE(1'b1)) uut (
        .clk(clk), .clr(clr), .advance(wr_adv), .remote_word(rd_word),
        .addr(wr_addr), .lap(wr_lap), .ptr_word(wr_word),
        .empty(wr_empty), .full(wr_full)
    );

    lap_ptr_unit #(.DEPTH(DEPTH), .WRITE_SIDE(1'b0)) u_reader (
        .clk(clk), .clr(clr), .advance(rd_adv), .remote_word(wr_word),
        .addr(rd_addr), .lap(rd_lap), .ptr_word(rd_word),
        .empty(rd_empty), .full(rd_full)
    );

    lap_ptr_unit #(.DEPTH(1), .WRITE_SIDE(1'b1)) u_single (
        .clk(clk), .clr(clr), .advance(one_adv), .remote_word(2'b00),
        .addr(one_addr), .lap(one_lap), .ptr_word(one_word),
        .empty(one_empty), .full(one_full)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_pair();
        int occ;
        occ = wtot - rtot;
        check("R2/R3 write addr", int'(wr_addr), wtot % DEPTH);
        check("R3 write lap", int'(wr_lap), (wtot / DEPTH) % 2);
        check("R2/R3 read addr", int'(rd_addr), rtot % DEPTH);
        check("R3 read lap", int'(rd_lap), (rtot / DEPTH) % 2);
        check("R6 word layout", int'(wr_word), ((wtot / DEPTH) % 2) * 8 + wtot % DEPTH);
        check("R7 full", int'(wr_full), int'(occ == DEPTH));
        check("R7 write empty tied", int'(wr_empty), 0);
        check("R8 empty", int'(rd_empty), int'(occ == 0));
        check("R8 read full tied", int'(rd_full), 0);
        check("R5 range", int'(wr_addr <= 3'(DEPTH - 1)), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        bit wgo, rgo;
        // R1: clear state, with advances held high during clear
        wr_adv = 1'b1; rd_adv = 1'b1; one_adv = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 clear addr", int'(wr_addr), 0);
        check("R1 clear lap", int'(wr_lap), 0);
        check("R1 clear reader", int'(rd_word), 0);
        check("R1 clear single", int'(one_word), 0);
        clr = 1'b0; wr_adv = 1'b0; rd_adv = 1'b0; one_adv = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_pair();

        // Writer/reader race through several laps, four phases
        for (int i = 0; i < 400; i++) begin
            int ph;
            ph = i / 100;
            unique case (ph)
                0: begin wgo = 1'b1; rgo = (i % 7 == 6); end
                1: begin wgo = (i % 9 == 0); rgo = 1'b1; end
                2: begin wgo = (i % 3 != 0); rgo = (i % 2 == 0); end
                default: begin wgo = 1'b1; rgo = 1'b1; end
            endcase
            wr_adv = wgo && (wtot - rtot < DEPTH);
            rd_adv = rgo && (wtot - rtot > 0);
            @(posedge clk);
            if (wr_adv) wtot++;
            if (rd_adv) rtot++;
            @(negedge clk);
            check_pair();
        end
        wr_adv = 1'b0; rd_adv = 1'b0;

        // R4: hold with no advance
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_pair();

        // R9: depth of one, every advance is a wrap
        for (int k = 0; k < 6; k++) begin
            one_adv = (k % 3 != 2);
            @(posedge clk);
            if (one_adv) otot++;
            @(negedge clk);
            check("R9 single addr", int'(one_addr), 0);
            check("R9 single lap", int'(one_lap), otot % 2);
            check("R9 single full", int'(one_full), otot % 2);
        end
        one_adv = 1'b0;

        // R1: clear mid-run with advance asserted
        clr = 1'b1; wr_adv = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wtot = 0; rtot = 0;
        check("R1 clear mid-run addr", int'(wr_addr), 0);
        check("R1 clear mid-run lap", int'(wr_lap), 0);
        check("R1 clear single lap", int'(one_lap), 0);
        clr = 1'b0; wr_adv = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_pair();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule